// File: doc/BRIEF.md
# Saturating Clear-on-Read Event Counter Bank

This block holds a small set of event counters that software reads through a byte-wide register read port. Each counter adds one on every cycle that its event input is high. It stops at its ceiling and never wraps. Reading a counter returns its current value and sets the counter back to zero, so each read gives the number of events since the previous read.

A single active-low mode input, `wide_n`, picks the counter width for the whole bank. When `wide_n` is high the bank runs in legacy mode: every counter is 8 bits and stops at FFH. When `wide_n` is low the bank runs in extended mode: every counter is 16 bits and stops at FFFFH. In extended mode, reading a counter's low byte also copies that counter's high byte into one shared high-byte register at address 3EH. Software reads the counter address first and then 3EH to build the full 16-bit value.

A read is taken on the rising edge of the read strobe. A strobe held high for several cycles therefore counts as one read and clears the counter only once.

Top module: `evt_counter_bank`

## Requirements
- R1: With `wide_n` high (legacy mode), each counter counts up to 8'hFF and then holds at FF for every further event.
- R2: With `wide_n` low (extended mode), each counter counts up to 16'hFFFF and then holds at that value for every further event.
- R3: Counter i sits at address BASE_ADDR+i (the first counter at 25H). When the strobe rises on that address, the next cycle shows `rd_valid`=1 and the counter's low byte on `rd_data`, and the counter becomes zero.
- R4: In extended mode, a counter read copies that counter's high byte into the shared register at the same edge. A read of address 3EH returns the stored byte with `rd_valid`=1 and changes no counter.
- R5: In legacy mode, a counter read leaves the shared register unchanged. A read of 3EH gives `rd_valid`=0 and `rd_data`=00.
- R6: If an event arrives in the same cycle as a clearing read, the read returns the value from before the event and the counter then holds 1.
- R7: A strobe held high for several cycles produces one read and one clear. Events that arrive while the strobe stays high are counted.
- R8: A strobe edge on an address that maps to no counter and not to 3EH gives `rd_valid`=0 and `rd_data`=00, and clears no counter.
- R9: After a synchronous reset, every counter and the shared register are zero and `rd_valid` is 0.
- R10: Each counter counts only its own event input. An event on one counter has no effect on any other counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_n | input | 1 | Low selects 16-bit extended counters; high selects 8-bit legacy counters |
| cnt_evt | input | NUM_CNT | One event bit per counter; bit i counts toward counter i |
| rd_stb | input | 1 | Read strobe; a read happens on its rising edge |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | High for one cycle after a read of a mapped address |
| rd_data | output | 8 | Read data; 00 when `rd_valid` is low |

## Verification
The bench uses the default parameters: four counters at 25H..28H, the shared register at 3EH, and 8-bit addresses. With only four counters, addresses 24H and 3DH inside the same byte space stay unmapped, so the ignored-address case can be tested. The 16-bit ceiling is reachable in about 65 thousand event cycles, which is short enough to run the extended-mode saturation test directly. A table of counts run in both modes covers the byte boundary, the carry into the high byte and the 8-bit ceiling. Directed tests then cover:
- a read in the same cycle as an event;
- a strobe held high for several cycles;
- the shared register's behaviour in legacy mode;
- independence between counters.

// File: rtl/evt_cnt_pkg.sv
// Package: types and helpers shared by the counter bank.
// Assumes the widest counter mode is 16 bits and the bus is one byte wide.
package evt_cnt_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Ceiling for the selected mode: FFH in legacy mode, FFFFH in extended mode.
    function automatic cnt_t sat_ceiling(input logic legacy);
        return legacy ? cnt_t'({BYTE_W{1'b1}}) : {CNT_W{1'b1}};
    endfunction
endpackage

// File: rtl/evt_rd_edge.sv
// Turns a level read strobe into a one-cycle pulse on its rising edge.
// Assumes rd_stb is synchronous to clk.
module evt_rd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic pulse
);
    logic stb_q;

    // Remember last cycle's strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb;
    end

    assign pulse = stb & ~stb_q;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse) else $error("strobe produced two pulses"); // R7
endmodule

// File: rtl/evt_rd_decode.sv
// Decodes the read address, qualified by the strobe pulse, into one
// counter select per counter and a select for the shared high-byte register.
// Assumes NUM_CNT counters sit at consecutive addresses from BASE_ADDR,
// and that HI_ADDR lies outside that range.
module evt_rd_decode #(
    parameter int NUM_CNT   = 4,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h25,
    parameter int HI_ADDR   = 'h3E
) (
    input  logic              pulse,
    input  logic              legacy,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CNT-1:0] cnt_sel,
    output logic              hi_sel
);
    // One comparator per counter.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_sel
        assign cnt_sel[g] = pulse && (addr == ADDR_W'(BASE_ADDR + g));
    end

    // The shared register is visible only in extended mode.
    assign hi_sel = pulse && !legacy && (addr == ADDR_W'(HI_ADDR));
endmodule

// File: rtl/evt_sat_counter.sv
// One saturating counter that clears when read.
// A clear in the same cycle as an event loads 1, so that event is not lost.
// Assumes legacy selects the 8-bit ceiling and is otherwise steady.
module evt_sat_counter
    import evt_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic legacy,
    input  logic evt,
    input  logic clr,
    output cnt_t cnt_o
);
    cnt_t cnt_q;
    cnt_t ceiling;

    assign ceiling = sat_ceiling(legacy);

    // Count, saturate at the ceiling, or clear on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (clr)                      cnt_q <= evt ? cnt_t'(1) : '0;
        else if (evt && cnt_q < ceiling)   cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    AST_LEG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy && cnt_q == 16'h00FF && evt && !clr) |=> cnt_q == 16'h00FF)
        else $error("legacy counter left FF"); // R1
    AST_EXT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy && cnt_q == 16'hFFFF && evt && !clr) |=> cnt_q == 16'hFFFF)
        else $error("extended counter wrapped"); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt_q >= $past(cnt_q)) else $error("counter decreased without a read"); // R1
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> cnt_q == '0) else $error("read did not clear"); // R3
    AST_CLR_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt) |=> cnt_q == 16'd1) else $error("event lost at read"); // R6
endmodule

// File: rtl/evt_counter_bank.sv
// Top level of the bank: edge detection on the strobe, address decode,
// NUM_CNT saturating counters, the shared high-byte register and the read
// data register. Read data appears one cycle after the strobe edge.
// Assumes wide_n is already synchronous to clk (low = 16-bit counters).
module evt_counter_bank
    import evt_cnt_pkg::*;
#(
    parameter int NUM_CNT   = 4,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h25,
    parameter int HI_ADDR   = 'h3E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_n,
    input  logic [NUM_CNT-1:0] cnt_evt,
    input  logic               rd_stb,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_valid,
    output logic [7:0]         rd_data
);
    logic               legacy;
    logic               pulse;
    logic [NUM_CNT-1:0] cnt_sel;
    logic               hi_sel;
    logic               any_cnt;
    logic               cap_en;
    cnt_t               cnt_all [NUM_CNT];
    byte_t              lo_mux;
    byte_t              hi_mux;
    byte_t              hi_q;

    assign legacy = wide_n;

    evt_rd_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (rd_stb),
        .pulse (pulse)
    );

    evt_rd_decode #(
        .NUM_CNT   (NUM_CNT),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .HI_ADDR   (HI_ADDR)
    ) u_dec (
        .pulse   (pulse),
        .legacy  (legacy),
        .addr    (rd_addr),
        .cnt_sel (cnt_sel),
        .hi_sel  (hi_sel)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        evt_sat_counter u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .legacy (legacy),
            .evt    (cnt_evt[g]),
            .clr    (cnt_sel[g]),
            .cnt_o  (cnt_all[g])
        );
    end

    // Select the addressed counter's low and high bytes (selects are one-hot).
    always_comb begin
        lo_mux = '0;
        hi_mux = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (cnt_sel[i]) begin
                lo_mux = lo_mux | cnt_all[i][BYTE_W-1:0];
                hi_mux = hi_mux | cnt_all[i][CNT_W-1:BYTE_W];
            end
        end
    end

    assign any_cnt = |cnt_sel;
    assign cap_en  = any_cnt && !legacy;

    // Copy the high byte on an extended-mode counter read.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (cap_en) hi_q <= hi_mux;
    end

    // Register the read result for one cycle; 00 when nothing was read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= any_cnt | hi_sel;
            rd_data  <= any_cnt ? lo_mux : (hi_sel ? hi_q : '0);
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_sel, hi_sel})) else $error("two read targets at once"); // R3
    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(hi_q)) else $error("shared register changed without capture"); // R4
    AST_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_stb)) else $error("valid without a strobe"); // R3
    AST_LEG_NOHI: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy && !any_cnt) |-> !hi_sel) else $error("high byte visible in legacy mode"); // R5
endmodule

// File: tb/evt_counter_bank_tb.sv
`timescale 1ns/1ps
module evt_counter_bank_tb_top;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wide_n = 1'b0;
    logic [NC-1:0] cnt_evt = '0;
    logic          rd_stb = 1'b0;
    logic [7:0]    rd_addr = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    evt_counter_bank #(.NUM_CNT(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wide_n(wide_n), .cnt_evt(cnt_evt),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Vector table: mode, counter, event count, expected low and high bytes.
    localparam int NV = 7;
    localparam bit        V_LEG [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int        V_IDX [NV] = '{0, 1, 2, 3, 0, 2, 1};
    localparam int        V_N   [NV] = '{5, 300, 300, 255, 256, 256, 1};
    localparam logic [7:0] V_LO [NV] = '{8'h05, 8'hFF, 8'h2C, 8'hFF, 8'h00, 8'hFF, 8'h01};
    localparam logic [7:0] V_HI [NV] = '{8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h00};

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic fire(input logic [NC-1:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cnt_evt = mask;
        end
        @(negedge clk);
        cnt_evt = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        rd_addr = a;
        rd_stb  = 1'b1;
        @(negedge clk);
        d = rd_data;
        v = rd_valid;
        rd_stb = 1'b0;
    endtask

    initial begin
        logic [7:0] d;
        logic       v;
        repeat (3) @(negedge clk);
        check("R9", "valid in reset", {7'd0, rd_valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "valid after reset", {7'd0, rd_valid}, 8'h00);
        for (int i = 0; i < NC; i++) begin
            do_read(8'(8'h25 + i), d, v);
            check("R9", "counter after reset", d, 8'h00);
        end
        do_read(8'h3E, d, v);
        check("R9", "shared reg after reset", d, 8'h00);

        // Table walk.
        for (int j = 0; j < NV; j++) begin
            wide_n = V_LEG[j];
            fire(NC'(1 << V_IDX[j]), V_N[j]);
            do_read(8'(8'h25 + V_IDX[j]), d, v);
            check("R3", "valid on counter read", {7'd0, v}, 8'h01);
            check(V_LEG[j] ? "R1" : "R2", "low byte", d, V_LO[j]);
            if (!V_LEG[j]) begin
                do_read(8'h3E, d, v);
                check("R4", "high byte", d, V_HI[j]);
            end
            do_read(8'(8'h25 + V_IDX[j]), d, v);
            check("R3", "cleared after read", d, 8'h00);
        end

        // R2: 16-bit saturation.
        wide_n = 1'b0;
        fire(4'b1000, 65537);
        do_read(8'h28, d, v);
        check("R2", "sat low", d, 8'hFF);
        do_read(8'h3E, d, v);
        check("R2", "sat high", d, 8'hFF);
        // R4: re-reading the shared register has no side effect.
        do_read(8'h3E, d, v);
        check("R4", "shared reread", d, 8'hFF);
        check("R4", "shared valid", {7'd0, v}, 8'h01);

        // R6: event in the same cycle as the read.
        fire(4'b0001, 7);
        @(negedge clk);
        rd_addr = 8'h25; rd_stb = 1'b1; cnt_evt = 4'b0001;
        @(negedge clk);
        d = rd_data; rd_stb = 1'b0; cnt_evt = '0;
        check("R6", "value before event", d, 8'h07);
        do_read(8'h25, d, v);
        check("R6", "event kept", d, 8'h01);

        // R7: long strobe, one clear only.
        fire(4'b0010, 4);
        @(negedge clk);
        rd_addr = 8'h26; rd_stb = 1'b1;
        @(negedge clk);
        check("R7", "first read", rd_data, 8'h04);
        cnt_evt = 4'b0010;
        @(negedge clk);
        check("R7", "no second read", {7'd0, rd_valid}, 8'h00);
        @(negedge clk);
        cnt_evt = '0; rd_stb = 1'b0;
        do_read(8'h26, d, v);
        check("R7", "events during hold", d, 8'h02);

        // R8: unmapped addresses.
        fire(4'b0001, 3);
        do_read(8'h24, d, v);
        check("R8", "unmapped 24 valid", {7'd0, v}, 8'h00);
        check("R8", "unmapped 24 data", d, 8'h00);
        do_read(8'h3D, d, v);
        check("R8", "unmapped 3D valid", {7'd0, v}, 8'h00);
        do_read(8'h25, d, v);
        check("R8", "counter untouched", d, 8'h03);

        // R5: legacy mode leaves the shared register alone.
        fire(4'b0100, 300);
        do_read(8'h27, d, v);
        do_read(8'h3E, d, v);
        check("R4", "captured high", d, 8'h01);
        wide_n = 1'b1;
        fire(4'b0100, 5);
        do_read(8'h27, d, v);
        check("R1", "legacy count", d, 8'h05);
        do_read(8'h3E, d, v);
        check("R5", "shared hidden valid", {7'd0, v}, 8'h00);
        check("R5", "shared hidden data", d, 8'h00);
        wide_n = 1'b0;
        do_read(8'h3E, d, v);
        check("R5", "shared kept", d, 8'h01);

        // R10: independence.
        fire(4'b0101, 3);
        fire(4'b0001, 2);
        do_read(8'h25, d, v); check("R10", "cnt0", d, 8'h05);
        do_read(8'h26, d, v); check("R10", "cnt1", d, 8'h00);
        do_read(8'h27, d, v); check("R10", "cnt2", d, 8'h03);
        do_read(8'h28, d, v); check("R10", "cnt3", d, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule